// File: doc/BRIEF.md
# Daisy-Chained Converter Readback Controller

This block is the host end of a three-wire link to a daisy chain of identical 14-bit successive-approximation converters. On a start request it raises the convert line while the serial clock rests high. That combination puts every converter in the chain into chained operation with an end-of-conversion flag. The controller then holds the convert line high and watches the serial data line from the nearest converter. That line goes high once every converter in the chain has finished. The controller treats this rising level as its interrupt.

After the interrupt the controller issues a fixed burst of serial clocks: one clock per data bit of every device, plus one more. It samples the data line on each falling clock edge. The first sample is the end-of-conversion flag and is dropped. The remaining bits are packed into one result word per device. When the last clock completes, the controller lowers the convert line, presents the words with a one-cycle strobe and returns to idle. If the interrupt does not arrive within a set number of cycles, the cycle is abandoned and an error pulse is raised instead.

The number of devices, the word width, the clock half-period in system cycles and the timeout are all compile-time parameters.

Top module: `chain_rd_host`

## Requirements
- R1: While reset is applied and right after it: `cnv_o` is 0, `sck_o` is 1, `valid_o` is 0 and `tmo_o` is 0.
- R2: A `start_i` pulse in idle raises `cnv_o` on the next clock edge while `sck_o` is 1. `sck_o` stays at 1 until the data line rises.
- R3: `cnv_o` stays 1 from its rise until the final serial clock has returned high. `sck_o` never falls while `cnv_o` is 0.
- R4: After a rise of `sdo_i` while waiting, exactly NUM_DEV×WORD_W+1 falling edges appear on `sck_o`.
- R5: The value of `sdo_i` at each falling edge of `sck_o` is captured. The first capture is dropped. The next bits fill the words MSB first, nearest device first. Word k (k=0 is the nearest device) appears at `words_o[k*WORD_W +: WORD_W]`.
- R6: During readback each low phase of `sck_o` lasts exactly HALF_DIV system clocks, and so does each high phase between pulses.
- R7: `cnv_o` falls in the same cycle as the final rise of `sck_o`. In the first cycle with `cnv_o` low, `valid_o` is 1 for exactly one cycle. `words_o` then holds the results.
- R8: `start_i` has no effect while a cycle is in progress. No second rise of `cnv_o` occurs and the results are unchanged.
- R9: If `sdo_i` has not risen within TIMEOUT_CYC cycles of the rise of `cnv_o`, then `cnv_o` falls after exactly TIMEOUT_CYC cycles high. `tmo_o` pulses for one cycle, no serial clocks are issued and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a conversion and readback cycle |
| sdo_i | input | 1 | Serial data / end-of-conversion flag from the nearest device |
| cnv_o | output | 1 | Convert line to all devices |
| sck_o | output | 1 | Serial clock to all devices, rests high |
| words_o | output | NUM_DEV*WORD_W | Result words, nearest device in the lowest slice |
| valid_o | output | 1 | One-cycle strobe marking fresh results |
| tmo_o | output | 1 | One-cycle pulse when the end-of-conversion flag never arrived |

## Verification
The hardest situations to reach are an end-of-conversion flag that lands just before the timeout expires, and start requests that arrive in the middle of the waiting and shifting phases. The bench models the chain as a frame that shifts on each falling serial clock. It draws conversion delays from a seeded generator and adds directed delays at the shortest legal value and a few cycles short of the timeout. It injects stray start pulses into both busy phases of every run. A final run never raises the flag, so the abandon path is exercised.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;

  // serial clocks needed for a chain: every data bit plus the flag bit
  function automatic int unsigned rd_clock_count(int unsigned n_dev, int unsigned w);
    return n_dev * w + 1;
  endfunction

endpackage

// File: rtl/chain_rd_sckgen.sv
module chain_rd_sckgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign fall_o = tick && sck_q;
  assign rise_o = tick && !sck_q;
  assign sck_o  = sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  // R6
  sck_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != $past(sck_q)) |-> ($past(cnt_q) == LAST || !$past(run_i)));

endmodule

// File: rtl/chain_rd_eoc.sv
module chain_rd_eoc #(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sdo_i,
  output logic done_o,
  output logic expire_o
);

  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYC - 1);

  logic [2:0]    sync_q;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          rise;

  assign rise     = sync_q[1] && !sync_q[2];
  assign done_o   = arm_i && rise;
  assign expire_o = arm_i && !rise && (tcnt_q == TLAST);

  always_comb begin
    tcnt_d = tcnt_q;
    if (!arm_i)      tcnt_d = '0;
    else if (!rise)  tcnt_d = tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      tcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sdo_i};
      tcnt_q <= tcnt_d;
    end
  end

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |-> (tcnt_q < TW'(TIMEOUT_CYC)));

endmodule

// File: rtl/chain_rd_capture.sv
module chain_rd_capture #(
  parameter int unsigned NUM_DEV = 3,
  parameter int unsigned WORD_W  = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_i,
  input  logic                        bit_i,
  output logic [NUM_DEV*WORD_W-1:0]   words_o
);

  localparam int unsigned NB = NUM_DEV * WORD_W;

  logic [NB-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_i) sh_d = {sh_q[NB-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // nearest device arrives first, so it ends in the top slice of the shifter
  for (genvar k = 0; k < NUM_DEV; k++) begin : g_word
    assign words_o[k*WORD_W +: WORD_W] = sh_q[(NUM_DEV-1-k)*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/chain_rd_host.sv
module chain_rd_host
  import chain_rd_pkg::*;
#(
  parameter int unsigned NUM_DEV     = 3,
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      sdo_i,
  output logic                      cnv_o,
  output logic                      sck_o,
  output logic [NUM_DEV*WORD_W-1:0] words_o,
  output logic                      valid_o,
  output logic                      tmo_o
);

  localparam int unsigned TOTAL = rd_clock_count(NUM_DEV, WORD_W);
  localparam int unsigned BCW   = $clog2(TOTAL + 1);
  localparam logic [BCW-1:0] BLAST = BCW'(TOTAL);

  logic [1:0]     rsync_q;
  logic           rst_n_s;
  rd_state_e      state_q, state_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic           cnv_q, cnv_d;
  logic           valid_q, valid_d;
  logic           tmo_q, tmo_d;
  logic           sck_run, sck_fall, sck_rise;
  logic           eoc_done, eoc_expire;
  logic           cap_shift;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  assign sck_run   = (state_q == ST_SHIFT);
  assign cap_shift = sck_fall && (bcnt_q != '0);

  chain_rd_sckgen #(.HALF_DIV(HALF_DIV)) sckgen_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (sck_run),
    .sck_o  (sck_o),
    .fall_o (sck_fall),
    .rise_o (sck_rise)
  );

  chain_rd_eoc #(.TIMEOUT_CYC(TIMEOUT_CYC)) eoc_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arm_i    (state_q == ST_WAIT),
    .sdo_i    (sdo_i),
    .done_o   (eoc_done),
    .expire_o (eoc_expire)
  );

  chain_rd_capture #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) cap_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .shift_i (cap_shift),
    .bit_i   (sdo_i),
    .words_o (words_o)
  );

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    cnv_d   = cnv_q;
    valid_d = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        bcnt_d = '0;
        if (start_i) begin
          state_d = ST_WAIT;
          cnv_d   = 1'b1;
        end
      end
      ST_WAIT: begin
        if (eoc_done) begin
          state_d = ST_SHIFT;
        end else if (eoc_expire) begin
          state_d = ST_IDLE;
          cnv_d   = 1'b0;
          tmo_d   = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (sck_fall) bcnt_d = bcnt_q + 1'b1;
        if (sck_rise && bcnt_q == BLAST) begin
          state_d = ST_IDLE;
          cnv_d   = 1'b0;
          valid_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      cnv_q   <= 1'b0;
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      cnv_q   <= cnv_d;
      valid_q <= valid_d;
      tmo_q   <= tmo_d;
    end
  end

  assign cnv_o   = cnv_q;
  assign valid_o = valid_q;
  assign tmo_o   = tmo_q;

  // R2
  cnv_rise_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(cnv_o) |-> sck_o);

  // R3
  sck_rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cnv_o |-> sck_o);

  // R4
  clock_budget_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bcnt_q <= BLAST);

  // R7
  valid_after_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_o |-> (!cnv_o && $fell(cnv_o)));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_o |=> !valid_o);

  // R9
  tmo_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    tmo_o |-> (!valid_o && !cnv_o && sck_o));

  // R9
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    tmo_o |=> !tmo_o);

endmodule

// File: tb/chain_rd_host_tb_top.sv
module chain_rd_host_tb_top;

  localparam int unsigned N    = 3;
  localparam int unsigned W    = 14;
  localparam int unsigned HALF = 2;
  localparam int unsigned TMO  = 400;
  localparam int unsigned NB   = N * W;

  logic clk, rst_n, start_i, sdo_i;
  logic cnv_o, sck_o, valid_o, tmo_o;
  logic [NB-1:0] words_o;

  int unsigned n_chk, n_bad;

  chain_rd_host #(.NUM_DEV(N), .WORD_W(W), .HALF_DIV(HALF), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .words_o(words_o), .valid_o(valid_o), .tmo_o(tmo_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // chain model: frame = flag bit, then words nearest device first
  logic [NB:0]  frame;
  logic         dev_done;
  int unsigned  fall_cnt, fall_base, fall_nocnv;
  int unsigned  rise_cnt, rise_sck_low, valid_cnt, tmo_cnt, hi_cnt, bad_width;
  time          fall_t;
  bit           fall_seen;

  initial begin
    fall_cnt = 0; fall_nocnv = 0; fall_seen = 0; fall_t = 0; bad_width = 0;
    rise_cnt = 0; rise_sck_low = 0; valid_cnt = 0; tmo_cnt = 0; hi_cnt = 0;
  end

  always_comb begin
    int unsigned idx;
    idx = fall_cnt - fall_base;
    sdo_i = dev_done && (idx <= NB) ? frame[NB - idx] : 1'b0;
  end

  always @(negedge sck_o) begin
    fall_t = $time;
    fall_seen = 1;
    if (!cnv_o) fall_nocnv++;
    #1 fall_cnt++;
  end

  always @(posedge sck_o) begin
    if (fall_seen && (($time - fall_t) / 10) != HALF) bad_width++;
  end

  always @(posedge cnv_o) begin
    rise_cnt++;
    if (!sck_o) rise_sck_low++;
  end

  always @(negedge clk) begin
    if (valid_o) valid_cnt++;
    if (tmo_o)   tmo_cnt++;
    if (cnv_o)   hi_cnt++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pack_words(input logic [W-1:0] w [N]);
    logic [NB-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = w[k];
    return v;
  endfunction

  function automatic logic [NB:0] build_frame(input logic [W-1:0] w [N]);
    logic [NB:0] f;
    f[NB] = 1'b1;
    for (int k = 0; k < N; k++) f[NB-1-k*W -: W] = w[k];
    return f;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_op(input int unsigned delay);
    logic [W-1:0] w [N];
    logic [NB-1:0] exp_v;
    int unsigned r0, v0, b0, nc0, guard;
    for (int k = 0; k < N; k++) w[k] = W'($urandom);
    exp_v = pack_words(w);
    frame = build_frame(w);
    dev_done = 1'b0;
    fall_base = fall_cnt;
    r0 = rise_cnt; v0 = valid_cnt; b0 = bad_width; nc0 = fall_nocnv;
    pulse_start();
    check(cnv_o === 1'b1, "R2 cnv raised", longint'(cnv_o), 1);
    pulse_start();                    // stray request while waiting (R8)
    repeat (delay) @(negedge clk);
    check(fall_cnt == fall_base, "R2 no clocks before flag", fall_cnt - fall_base, 0);
    dev_done = 1'b1;
    repeat (8) @(negedge clk);
    pulse_start();                    // stray request while shifting (R8)
    guard = 0;
    while (!valid_o && guard < 2000) begin @(negedge clk); guard++; end
    check(valid_o === 1'b1, "R7 valid seen", longint'(valid_o), 1);
    check(cnv_o === 1'b0, "R7 cnv low at valid", longint'(cnv_o), 0);
    check(words_o == exp_v, "R5 words", longint'(words_o), longint'(exp_v));
    check(fall_cnt - fall_base == NB + 1, "R4 clock count", fall_cnt - fall_base, NB + 1);
    check(fall_nocnv == nc0, "R3 cnv held", fall_nocnv - nc0, 0);
    check(bad_width == b0, "R6 phase width", bad_width - b0, 0);
    @(negedge clk);
    check(valid_o === 1'b0, "R7 single pulse", longint'(valid_o), 0);
    repeat (20) @(negedge clk);
    check(valid_cnt - v0 == 1, "R7 strobe count", valid_cnt - v0, 1);
    check(rise_cnt - r0 == 1, "R8 one cnv rise", rise_cnt - r0, 1);
    check(cnv_o === 1'b0, "R8 idle after", longint'(cnv_o), 0);
    check(words_o == exp_v, "R8 words held", longint'(words_o), longint'(exp_v));
    dev_done = 1'b0;
  endtask

  initial begin
    int unsigned h0, f0, v0, t0, guard;
    void'($urandom(32'd2718));
    n_chk = 0; n_bad = 0;
    start_i = 1'b0; dev_done = 1'b0; frame = '0; fall_base = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cnv_o === 1'b0 && valid_o === 1'b0 && tmo_o === 1'b0, "R1 reset outputs low",
          longint'({cnv_o, valid_o, tmo_o}), 0);
    check(sck_o === 1'b1, "R1 sck rests high", longint'(sck_o), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cnv_o === 1'b0 && sck_o === 1'b1, "R1 after release",
          longint'({cnv_o, sck_o}), 1);

    run_op(2);            // shortest wait
    run_op(390);          // flag just before the timeout
    for (int i = 0; i < 8; i++) run_op(3 + ($urandom % 150));
    check(rise_sck_low == 0, "R2 sck high at cnv rise", rise_sck_low, 0);

    // flag never arrives
    dev_done = 1'b0;
    h0 = hi_cnt; f0 = fall_cnt; v0 = valid_cnt; t0 = tmo_cnt;
    pulse_start();
    guard = 0;
    while (cnv_o && guard < 1000) begin @(negedge clk); guard++; end
    repeat (5) @(negedge clk);
    check(hi_cnt - h0 == TMO, "R9 wait length", hi_cnt - h0, TMO);
    check(tmo_cnt - t0 == 1, "R9 error pulse", tmo_cnt - t0, 1);
    check(fall_cnt == f0, "R9 no clocks", fall_cnt - f0, 0);
    check(valid_cnt == v0, "R9 no valid", valid_cnt - v0, 0);

    run_op(40);           // recovers after an abandoned cycle

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog expired actual=hang expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule